// File: doc/BRIEF.md
# Memory and Peripheral Security Gate

This block sits between the bus masters and the on-chip SRAM and peripheral space and decides, request by request, whether an access may reach its target. Every resource is reachable through two address aliases that differ only in address bit 28: bit 28 = 0 is the secure alias and bit 28 = 1 is the non-secure alias. Each SRAM block and each peripheral carries one configuration bit that says whether it currently belongs to the secure or the non-secure side. An access passes only when the alias it uses agrees with the target's configured side and the requesting master is entitled to that side.

Blocked requests are never forwarded. The requester sees an error flag and zero read data in the same cycle. One cycle later an interrupt line pulses, together with a flag that records whether a CPU or another bus master caused the violation. The two configuration registers are written through a small side port. Only secure masters can change them, and a fixed set of critical peripherals can never leave the secure side.

Top module: `sgate_top`

## Requirements
- R1: After reset every SRAM block bit and every peripheral bit is 0 (secure), and `viol_irq`, `viol_dma` and `cfg_err` are 0.
- R2: Addresses with bits [31:29] = 3'b001 are SRAM. The block index is bits [27:13] (8 KB blocks), and block n follows bit n of `sram_ns`. Addresses with bits [31:29] = 3'b010 are peripherals. The peripheral index is bits [27:12] (4 KB slots), and slot n follows bit n of `periph_ns`. An SRAM index of 12 or more, or a peripheral index of 16 or more, is blocked.
- R3: A secure master (`req_ns` = 0) is allowed only when address bit 28 equals the target's configuration bit. It is blocked on the secure alias of a non-secure target and on the non-secure alias of a secure target.
- R4: A non-secure master (`req_ns` = 1), whether CPU or other master, is allowed only when address bit 28 = 1 and the target's bit is 1.
- R5: For a blocked request, `fwd_valid` and `fwd_write` are 0, `req_err` is 1 and `rsp_rdata` is 0, all in the same cycle.
- R6: For an allowed request, `fwd_valid` = 1, `fwd_write` follows `req_write`, `req_err` = 0 and `rsp_rdata` equals `mem_rdata`, all in the same cycle.
- R7: Addresses outside the two windows are forwarded for either master, whatever bit 28 holds.
- R8: `viol_irq` is 1 in the cycle after a blocked request and 0 in the cycle after any other cycle. `viol_dma` then holds that request's `req_dma`.
- R9: A configuration write from a secure master takes effect at the next clock edge. `cfg_sel` = 0 loads `sram_ns` from `cfg_wdata[11:0]`, and `cfg_sel` = 1 loads `periph_ns` from `cfg_wdata[15:0]`.
- R10: Peripheral slots 0 and 1 are locked secure. Their bits in `periph_ns` stay 0 whatever is written.
- R11: A configuration write from a non-secure master (`cfg_ns` = 1) leaves both registers unchanged and makes `cfg_err` 1 for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data |
| req_ns | input | 1 | 1 = non-secure master |
| req_dma | input | 1 | 1 = non-CPU bus master |
| fwd_valid | output | 1 | Request forwarded to target |
| fwd_addr | output | 32 | Forwarded address |
| fwd_write | output | 1 | Forwarded write strobe |
| fwd_wdata | output | 32 | Forwarded write data |
| mem_rdata | input | 32 | Read data from target |
| rsp_rdata | output | 32 | Read data to requester |
| req_err | output | 1 | Error response for blocked request |
| viol_irq | output | 1 | Violation interrupt pulse |
| viol_dma | output | 1 | Master type of last violation |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = SRAM register, 1 = peripheral register |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_ns | input | 1 | 1 = configuring master is non-secure |
| cfg_err | output | 1 | Rejected configuration write pulse |
| sram_ns | output | 12 | SRAM block side bits |
| periph_ns | output | 16 | Peripheral side bits |

## Verification
The forward, error and read-data results depend only on the current request and the stored bits, so they are due in the same cycle. The bench drives each request just after a falling edge and samples these results a quarter period later, before the next rising edge. The violation pulse, the master-type flag, the configuration error and the register contents are due one rising edge after their cause, so the bench samples them just after that edge. It also confirms that each of these results drops again one edge after the cause goes away.

// File: rtl/sgate_pkg.sv
package sgate_pkg;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_SRAM   = 2'd1,
    TGT_PERIPH = 2'd2
  } tgt_kind_e;

  // Access rule: secure masters need alias == target side,
  // non-secure masters need both alias and target non-secure.
  function automatic logic gate_allow(input logic master_ns,
                                      input logic alias_ns,
                                      input logic target_ns);
    if (master_ns) return alias_ns & target_ns;
    return alias_ns == target_ns;
  endfunction

  // Window decode on the top address bits.
  function automatic tgt_kind_e window_of(input logic [2:0] top_bits);
    case (top_bits)
      3'b001:  return TGT_SRAM;
      3'b010:  return TGT_PERIPH;
      default: return TGT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sgate_cfg.sv
module sgate_cfg #(
  parameter int SRAM_BLKS = 12,
  parameter int N_PERIPH  = 16,
  parameter logic [N_PERIPH-1:0] LOCK_MASK = 16'h0003,
  localparam int CFG_W = (SRAM_BLKS > N_PERIPH) ? SRAM_BLKS : N_PERIPH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 cfg_ns,
  output logic [SRAM_BLKS-1:0] sram_ns,
  output logic [N_PERIPH-1:0]  periph_ns,
  output logic                 cfg_err
);

  logic wr_ok;
  logic wr_bad;

  assign wr_ok  = cfg_wr & ~cfg_ns;
  assign wr_bad = cfg_wr &  cfg_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ns   <= '0;
      periph_ns <= '0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err <= wr_bad;
      if (wr_ok && !cfg_sel) sram_ns   <= cfg_wdata[SRAM_BLKS-1:0];
      if (wr_ok &&  cfg_sel) periph_ns <= cfg_wdata[N_PERIPH-1:0] & ~LOCK_MASK;
    end
  end

endmodule

// File: rtl/sgate_lookup.sv
module sgate_lookup
  import sgate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SRAM_BLKS = 12,
  parameter int BLK_AW    = 13,
  parameter int N_PERIPH  = 16,
  parameter int PER_AW    = 12,
  localparam int ALIAS_BIT = 28,
  localparam int SRAM_IW   = ALIAS_BIT - BLK_AW,
  localparam int PER_IW    = ALIAS_BIT - PER_AW
) (
  input  logic [ADDR_W-1:PER_AW]  page,
  input  logic [SRAM_BLKS-1:0]    sram_ns,
  input  logic [N_PERIPH-1:0]     periph_ns,
  output tgt_kind_e               kind,
  output logic                    idx_ok,
  output logic                    target_ns,
  output logic                    alias_ns
);

  logic [SRAM_IW-1:0] sram_idx;
  logic [PER_IW-1:0]  per_idx;
  logic               sram_hit;
  logic               sram_bit;
  logic               per_hit;
  logic               per_bit;

  assign kind     = window_of(page[ADDR_W-1:ALIAS_BIT+1]);
  assign alias_ns = page[ALIAS_BIT];
  assign sram_idx = page[ALIAS_BIT-1:BLK_AW];
  assign per_idx  = page[ALIAS_BIT-1:PER_AW];

  always_comb begin
    sram_hit = 1'b0;
    sram_bit = 1'b0;
    for (int i = 0; i < SRAM_BLKS; i++) begin
      if (sram_idx == SRAM_IW'(i)) begin
        sram_hit = 1'b1;
        sram_bit = sram_ns[i];
      end
    end
  end

  always_comb begin
    per_hit = 1'b0;
    per_bit = 1'b0;
    for (int i = 0; i < N_PERIPH; i++) begin
      if (per_idx == PER_IW'(i)) begin
        per_hit = 1'b1;
        per_bit = periph_ns[i];
      end
    end
  end

  always_comb begin
    case (kind)
      TGT_SRAM:   begin idx_ok = sram_hit; target_ns = sram_bit; end
      TGT_PERIPH: begin idx_ok = per_hit;  target_ns = per_bit;  end
      default:    begin idx_ok = 1'b1;     target_ns = 1'b0;     end
    endcase
  end

endmodule

// File: rtl/sgate_top.sv
module sgate_top
  import sgate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SRAM_BLKS = 12,
  parameter int BLK_AW    = 13,
  parameter int N_PERIPH  = 16,
  parameter int PER_AW    = 12,
  parameter logic [N_PERIPH-1:0] LOCK_MASK = 16'h0003,
  localparam int CFG_W = (SRAM_BLKS > N_PERIPH) ? SRAM_BLKS : N_PERIPH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 req_ns,
  input  logic                 req_dma,
  output logic                 fwd_valid,
  output logic [ADDR_W-1:0]    fwd_addr,
  output logic                 fwd_write,
  output logic [DATA_W-1:0]    fwd_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 req_err,
  output logic                 viol_irq,
  output logic                 viol_dma,
  input  logic                 cfg_wr,
  input  logic                 cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 cfg_ns,
  output logic                 cfg_err,
  output logic [SRAM_BLKS-1:0] sram_ns,
  output logic [N_PERIPH-1:0]  periph_ns
);

  tgt_kind_e kind;
  logic      idx_ok;
  logic      target_ns;
  logic      alias_ns;
  logic      in_window;
  logic      allow;
  logic      blocked;

  sgate_cfg #(
    .SRAM_BLKS (SRAM_BLKS),
    .N_PERIPH  (N_PERIPH),
    .LOCK_MASK (LOCK_MASK)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_ns    (cfg_ns),
    .sram_ns   (sram_ns),
    .periph_ns (periph_ns),
    .cfg_err   (cfg_err)
  );

  sgate_lookup #(
    .ADDR_W    (ADDR_W),
    .SRAM_BLKS (SRAM_BLKS),
    .BLK_AW    (BLK_AW),
    .N_PERIPH  (N_PERIPH),
    .PER_AW    (PER_AW)
  ) u_lookup (
    .page      (req_addr[ADDR_W-1:PER_AW]),
    .sram_ns   (sram_ns),
    .periph_ns (periph_ns),
    .kind      (kind),
    .idx_ok    (idx_ok),
    .target_ns (target_ns),
    .alias_ns  (alias_ns)
  );

  assign in_window = (kind != TGT_NONE);
  assign allow     = !in_window || (idx_ok && gate_allow(req_ns, alias_ns, target_ns));
  assign blocked   = req_valid & ~allow;

  assign fwd_valid = req_valid & allow;
  assign fwd_addr  = req_addr;
  assign fwd_write = req_write & allow;
  assign fwd_wdata = req_wdata;
  assign rsp_rdata = allow ? mem_rdata : '0;
  assign req_err   = blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_irq <= 1'b0;
      viol_dma <= 1'b0;
    end else begin
      viol_irq <= blocked;
      if (blocked) viol_dma <= req_dma;
    end
  end

endmodule

// File: rtl/sgate_chk.sv
module sgate_chk #(
  parameter int SRAM_BLKS = 12,
  parameter int N_PERIPH  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [31:0]          req_addr,
  input logic                 req_ns,
  input logic                 fwd_valid,
  input logic [31:0]          rsp_rdata,
  input logic                 req_err,
  input logic                 viol_irq,
  input logic                 cfg_wr,
  input logic                 cfg_sel,
  input logic [15:0]          cfg_wdata,
  input logic                 cfg_ns,
  input logic                 cfg_err,
  input logic [SRAM_BLKS-1:0] sram_ns,
  input logic [N_PERIPH-1:0]  periph_ns
);

  // R5
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!fwd_valid && rsp_rdata == '0));

  // R4
  ns_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && req_ns && (req_addr[31:29] == 3'b001 || req_addr[31:29] == 3'b010))
      |-> req_addr[28]);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> viol_irq);

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_err |=> !viol_irq);

  // R11
  ns_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_ns) |=> ($stable(sram_ns) && $stable(periph_ns) && cfg_err));

  // R9
  sram_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_ns && !cfg_sel) |=> (sram_ns == $past(cfg_wdata[SRAM_BLKS-1:0])));

  // R5
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid) |-> (!fwd_valid && !req_err));

endmodule

bind sgate_top sgate_chk #(
  .SRAM_BLKS (12),
  .N_PERIPH  (16)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_ns    (req_ns),
  .fwd_valid (fwd_valid),
  .rsp_rdata (rsp_rdata),
  .req_err   (req_err),
  .viol_irq  (viol_irq),
  .cfg_wr    (cfg_wr),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .cfg_ns    (cfg_ns),
  .cfg_err   (cfg_err),
  .sram_ns   (sram_ns),
  .periph_ns (periph_ns)
);

// File: tb/sgate_top_tb.sv
module sgate_top_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_ns = 1'b0;
  logic        req_dma = 1'b0;
  logic        fwd_valid, fwd_write;
  logic [31:0] fwd_addr, fwd_wdata, rsp_rdata;
  logic [31:0] mem_rdata = '0;
  logic        req_err, viol_irq, viol_dma;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        cfg_ns = 1'b0;
  logic        cfg_err;
  logic [11:0] sram_ns;
  logic [15:0] periph_ns;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sgate_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_ns(req_ns), .req_dma(req_dma),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_write(fwd_write),
    .fwd_wdata(fwd_wdata), .mem_rdata(mem_rdata), .rsp_rdata(rsp_rdata),
    .req_err(req_err), .viol_irq(viol_irq), .viol_dma(viol_dma),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_ns(cfg_ns),
    .cfg_err(cfg_err), .sram_ns(sram_ns), .periph_ns(periph_ns)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {addr, master_ns, dma, write, expect_allow}
  localparam int NV = 17;
  localparam logic [35:0] VEC [NV] = '{
    {32'h2000_0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 secure alias, NS block0
    {32'h3000_0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 NS alias, NS block0
    {32'h3000_0000, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 ns dma, NS block0
    {32'h2000_0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 secure alias
    {32'h2000_2000, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 S block1
    {32'h3000_2000, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 NS alias, S block1
    {32'h3000_2000, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 S block1
    {32'h3000_4000, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 NS block2
    {32'h3001_8000, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 block12 out of range
    {32'h4000_0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R10 locked periph0 secure
    {32'h5000_0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 periph0 from ns
    {32'h5000_4000, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 periph4 NS
    {32'h4000_4000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 periph4 secure alias
    {32'h4000_2000, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 periph2 secure alias
    {32'h4001_0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 periph16 out of range
    {32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 outside windows
    {32'h1000_0000, 1'b1, 1'b1, 1'b0, 1'b1}  // R7 outside windows
  };

  task automatic cfg_write(input logic sel, input logic [15:0] d, input logic ns);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_ns = ns;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_ns = 1'b0;
  endtask

  initial begin
    #(CLK_P * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sram_ns", 32'(sram_ns), 32'h0);
    check("R1 periph_ns", 32'(periph_ns), 32'h0);
    check("R1 viol_irq", 32'(viol_irq), 32'h0);
    check("R1 cfg_err", 32'(cfg_err), 32'h0);
    check("R1 viol_dma", 32'(viol_dma), 32'h0);

    // R9 secure configuration writes; R10 lock of slots 0,1
    cfg_write(1'b0, 16'h0005, 1'b0);
    check("R9 sram_ns", 32'(sram_ns), 32'h005);
    cfg_write(1'b1, 16'h00F3, 1'b0);
    check("R10 periph_ns locked", 32'(periph_ns), 32'h00F0);

    // R11 non-secure write ignored and flagged
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0FFF; cfg_ns = 1'b1;
    @(posedge clk); #1;
    check("R11 cfg_err", 32'(cfg_err), 32'h1);
    check("R11 sram_ns kept", 32'(sram_ns), 32'h005);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_ns = 1'b0;
    @(posedge clk); #1;
    check("R11 cfg_err drop", 32'(cfg_err), 32'h0);
    check("R11 periph_ns kept", 32'(periph_ns), 32'h00F0);

    // vector table: R2..R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = VEC[i][35:4];
      req_ns    = VEC[i][3];
      req_dma   = VEC[i][2];
      req_write = VEC[i][1];
      req_wdata = 32'hC0DE_0000 + 32'(i);
      mem_rdata = 32'hA5A5_0000 + 32'(i);
      #(CLK_P/4);
      if (VEC[i][0]) begin
        check($sformatf("R6 fwd_valid v%0d", i), 32'(fwd_valid), 32'h1);
        check($sformatf("R6 fwd_write v%0d", i), 32'(fwd_write), 32'(VEC[i][1]));
        check($sformatf("R6 rdata v%0d", i), rsp_rdata, 32'hA5A5_0000 + 32'(i));
        check($sformatf("R6 err v%0d", i), 32'(req_err), 32'h0);
      end else begin
        check($sformatf("R5 fwd_valid v%0d", i), 32'(fwd_valid), 32'h0);
        check($sformatf("R5 fwd_write v%0d", i), 32'(fwd_write), 32'h0);
        check($sformatf("R5 rdata v%0d", i), rsp_rdata, 32'h0);
        check($sformatf("R5 err v%0d", i), 32'(req_err), 32'h1);
      end
      @(posedge clk); #1;
      check($sformatf("R8 viol_irq v%0d", i), 32'(viol_irq), 32'(!VEC[i][0]));
      if (!VEC[i][0])
        check($sformatf("R8 viol_dma v%0d", i), 32'(viol_dma), 32'(VEC[i][2]));
    end

    // R8 pulse drops when idle
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    check("R8 idle no irq", 32'(viol_irq), 32'h0);

    // R9 reconfigure: block0 back to secure, takes effect next edge
    cfg_write(1'b0, 16'h0004, 1'b0);
    req_valid = 1'b1; req_addr = 32'h3000_0000; req_ns = 1'b1; req_write = 1'b0;
    #(CLK_P/4);
    check("R9 block0 now secure", 32'(req_err), 32'h1);
    req_ns = 1'b0; req_addr = 32'h2000_0000;
    #1;
    check("R3 secure alias now ok", 32'(fwd_valid), 32'h1);
    @(negedge clk);
    req_valid = 1'b0;

    // R7 outside window with secure master on bit 28 set
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hF000_0000; req_ns = 1'b0;
    #(CLK_P/4);
    check("R7 outside secure", 32'(fwd_valid), 32'h1);
    @(negedge clk);
    req_valid = 1'b0;

    // R1 reset returns everything to secure
    rst_n = 1'b0;
    #1;
    check("R1 reset clears sram", 32'(sram_ns), 32'h0);
    check("R1 reset clears periph", 32'(periph_ns), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule